// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes that an 8-bit microcontroller puts on its multiplexed external bus: an address-latch pulse (`ale`, active high) and a program-store read strobe (`psen_n`, active low). It divides the oscillator-rate clock into machine cycles of twelve periods. At each machine-cycle boundary it decides where the next fetch comes from: internal or external program memory. It also decides whether the cycle is an external data-memory transfer. The strobes are then shaped from that decision and from the current period.

The level on the external-access pin is captured while reset is active. Once reset is released, that captured level alone, together with the program counter, picks the fetch source. A software-controlled quiet bit keeps `ale` low to cut radiated noise. The block overrides the quiet bit when the bus is really in use. Idle and power-down inputs freeze the cycle and park the strobes at fixed levels.

Top module: `ext_bus_strobe`

## Requirements
- R1: A machine cycle is 12 clock periods, numbered 1 to 12. With the quiet bit clear, outside data cycles, `ale` is high exactly in periods 1 and 7 and low in all other periods.
- R2: In an external-fetch cycle that is not a data cycle, `psen_n` is low in periods 3, 4, 5, 9, 10 and 11 and high otherwise. In an internal-fetch cycle, `psen_n` stays high for the whole cycle.
- R3: A data cycle is marked by `data_req` being high on the clock edge that starts period 1. In a data cycle, `psen_n` stays high for all 12 periods. The `ale` pulse of period 7 is dropped and the pulse of period 1 is kept.
- R4: `ext_access_pin` is sampled on every edge while `rst` is high. Changes on the pin after reset have no effect on the fetch source.
- R5: The fetch source of a cycle is external if the captured pin level is 0 or `pc` >= 32768, and internal otherwise. `pc` is sampled on the edge that starts period 1. `fetch_ext` shows the source of the current cycle, with 1 meaning external.
- R6: With `ale_quiet` high, `ale` is held low through internal non-data cycles.
- R7: With `ale_quiet` high, data cycles and external-fetch cycles still produce their `ale` pulses exactly as in R1 and R3.
- R8: While `idle_mode` or `pdown_mode` is high with `ale_quiet` high, `ale` is high in idle and low in power-down. Power-down takes precedence when both are high. `psen_n` is high.
- R9: While `idle_mode` or `pdown_mode` is high with `ale_quiet` low, `ale` and `psen_n` are both high. In every low-power case the period count is frozen, and it resumes from the same period afterwards.
- R10: Reset drives `ale` high and `psen_n` high, sets the period to 1 and clears `fetch_ext`. The cycle in progress when reset is released counts as internal and not a data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_access_pin | input | 1 | External-access level, captured during reset |
| pc | input | 16 | Program counter of the next fetch |
| data_req | input | 1 | Next machine cycle is an external data transfer |
| idle_mode | input | 1 | Idle mode flag |
| pdown_mode | input | 1 | Power-down mode flag |
| ale_quiet | input | 1 | Software quiet bit that suppresses `ale` |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| fetch_ext | output | 1 | Source of the current cycle's fetch, 1 = external |

## Verification
Random stimulus varies `pc` around the 32768 limit, so the boundary between internal and external fetch is hit from both sides. Data requests are mixed with plain fetches, which separates a dropped period-7 pulse from a suppressed one. The quiet bit is toggled in every kind of cycle, so the checks tell its override apart from normal toggling. Idle and power-down episodes of random length test the frozen period and the parked levels. Resets are run with the pin both low and high, and the pin is then flipped after reset to show that only the captured level matters.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef struct packed {
        logic data_cyc;
        logic ext_fetch;
    } cyc_attr_t;

endpackage

// File: rtl/esg_phase.sv
module esg_phase #(
    parameter int CYCLE_LEN = 12,
    localparam int PH_W = $clog2(CYCLE_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    output logic [PH_W-1:0] phase_d,
    output logic            load
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (st_q.phase == PH_W'(CYCLE_LEN))
                st_d.phase = PH_W'(1);
            else
                st_d.phase = st_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.phase <= PH_W'(1);
        else     st_q <= st_d;
    end

    assign phase_d = st_d.phase;
    assign load    = !rst && !hold && (st_q.phase == PH_W'(CYCLE_LEN));

endmodule

// File: rtl/esg_source.sv
module esg_source
    import esg_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int INT_LIMIT = 32768
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ea_pin,
    input  logic [PC_W-1:0] pc,
    input  logic            data_req,
    input  logic            load,
    output cyc_attr_t       attr_d,
    output cyc_attr_t       attr_q,
    output logic            ea_lat
);

    localparam logic [PC_W:0] LIMIT = (PC_W+1)'(INT_LIMIT);

    typedef struct packed {
        logic      ea;
        cyc_attr_t attr;
    } src_state_t;

    src_state_t st_d, st_q;
    logic above_limit;

    always_comb begin
        above_limit = {1'b0, pc} >= LIMIT;
        st_d = st_q;
        if (rst) begin
            st_d.ea   = ea_pin;
            st_d.attr = '0;
        end else if (load) begin
            st_d.attr.data_cyc  = data_req;
            st_d.attr.ext_fetch = !st_q.ea || above_limit;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign attr_d = st_d.attr;
    assign attr_q = st_q.attr;
    assign ea_lat = st_q.ea;

endmodule

// File: rtl/esg_strobe.sv
module esg_strobe
    import esg_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    localparam int PH_W = $clog2(CYCLE_LEN + 1),
    localparam int HALF = CYCLE_LEN / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase_d,
    input  cyc_attr_t       attr_d,
    input  logic            hold,
    input  logic            pdown,
    input  logic            quiet,
    output logic            ale,
    output logic            psen_n
);

    typedef struct packed {
        logic ale;
        logic psen_n;
    } strobe_t;

    strobe_t st_d, st_q;
    logic slot_a, slot_b, in_win, ale_allowed;

    always_comb begin
        slot_a      = phase_d == PH_W'(1);
        slot_b      = (phase_d == PH_W'(HALF + 1)) && !attr_d.data_cyc;
        in_win      = (phase_d >= PH_W'(3) && phase_d <= PH_W'(HALF - 1)) ||
                      (phase_d >= PH_W'(HALF + 3) && phase_d <= PH_W'(CYCLE_LEN - 1));
        ale_allowed = !quiet || attr_d.data_cyc || attr_d.ext_fetch;
        if (hold) begin
            st_d.ale    = quiet ? !pdown : 1'b1;
            st_d.psen_n = 1'b1;
        end else begin
            st_d.ale    = (slot_a || slot_b) && ale_allowed;
            st_d.psen_n = !(in_win && attr_d.ext_fetch && !attr_d.data_cyc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ale    <= 1'b1;
            st_q.psen_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ale    = st_q.ale;
    assign psen_n = st_q.psen_n;

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
    import esg_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int PC_W      = 16,
    parameter int INT_LIMIT = 32768,
    localparam int PH_W = $clog2(CYCLE_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_access_pin,
    input  logic [PC_W-1:0] pc,
    input  logic            data_req,
    input  logic            idle_mode,
    input  logic            pdown_mode,
    input  logic            ale_quiet,
    output logic            ale,
    output logic            psen_n,
    output logic            fetch_ext
);

    logic            hold;
    logic            load;
    logic [PH_W-1:0] phase_d;
    cyc_attr_t       attr_d, attr_q;
    logic            ea_lat;

    assign hold = idle_mode || pdown_mode;

    esg_phase #(.CYCLE_LEN(CYCLE_LEN)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .phase_d (phase_d),
        .load    (load)
    );

    esg_source #(.PC_W(PC_W), .INT_LIMIT(INT_LIMIT)) u_src (
        .clk      (clk),
        .rst      (rst),
        .ea_pin   (ext_access_pin),
        .pc       (pc),
        .data_req (data_req),
        .load     (load),
        .attr_d   (attr_d),
        .attr_q   (attr_q),
        .ea_lat   (ea_lat)
    );

    esg_strobe #(.CYCLE_LEN(CYCLE_LEN)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .attr_d  (attr_d),
        .hold    (hold),
        .pdown   (pdown_mode),
        .quiet   (ale_quiet),
        .ale     (ale),
        .psen_n  (psen_n)
    );

    assign fetch_ext = attr_q.ext_fetch;

endmodule

// File: rtl/esg_checker.sv
module esg_checker (
    input logic clk,
    input logic rst,
    input logic idle_mode,
    input logic pdown_mode,
    input logic ale_quiet,
    input logic ale,
    input logic psen_n,
    input logic fetch_ext,
    input logic ea_lat
);

    // R2: the read strobe is only active in an external fetch cycle
    p_psen_needs_ext_r2: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> fetch_ext);

    // R1: address latch and read strobe never overlap
    p_ale_psen_apart_r1: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n));

    // R8: quiet power-down parks ale low
    p_pdown_quiet_low_r8: assert property (@(posedge clk) disable iff (rst)
        (pdown_mode && ale_quiet) |=> !ale);

    // R9: any low-power mode keeps the read strobe idle
    p_lowpower_psen_high_r9: assert property (@(posedge clk) disable iff (rst)
        (idle_mode || pdown_mode) |=> psen_n);

    // R4: captured pin level does not move outside reset
    p_ea_held_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(ea_lat));

    // R10: outputs right after a reset edge
    p_reset_levels_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ale && psen_n && !fetch_ext));

endmodule

bind ext_bus_strobe esg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .idle_mode  (idle_mode),
    .pdown_mode (pdown_mode),
    .ale_quiet  (ale_quiet),
    .ale        (ale),
    .psen_n     (psen_n),
    .fetch_ext  (fetch_ext),
    .ea_lat     (ea_lat)
);

// File: tb/ext_bus_strobe_test.sv
module ext_bus_strobe_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ea_pin = 1'b0;
    logic [15:0] pc = '0;
    logic        data_req = 1'b0;
    logic        idle_m = 1'b0;
    logic        pdown_m = 1'b0;
    logic        quiet = 1'b0;
    logic        ale, psen_n, fetch_ext;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ext_bus_strobe uut (
        .clk            (clk),
        .rst            (rst),
        .ext_access_pin (ea_pin),
        .pc             (pc),
        .data_req       (data_req),
        .idle_mode      (idle_m),
        .pdown_mode     (pdown_m),
        .ale_quiet      (quiet),
        .ale            (ale),
        .psen_n         (psen_n),
        .fetch_ext      (fetch_ext)
    );

    // reference model state, advanced from the requirements
    int m_ph  = 1;
    bit m_ea  = 1'b0;
    bit m_dc  = 1'b0;
    bit m_ex  = 1'b0;
    bit m_ale = 1'b1;
    bit m_ps  = 1'b1;

    function automatic bit want_ale(int ph, bit dc, bit ex, bit q);
        bit pulse;
        pulse = (ph == 1) || (ph == 7 && !dc);     // R1, R3
        return pulse && (!q || dc || ex);           // R6, R7
    endfunction

    function automatic bit want_psen_n(int ph, bit dc, bit ex);
        bit win;
        win = (ph >= 3 && ph <= 5) || (ph >= 9 && ph <= 11);  // R2
        return !(win && ex && !dc);                            // R3
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 1; m_ea <= ea_pin; m_dc <= 1'b0; m_ex <= 1'b0;
            m_ale <= 1'b1; m_ps <= 1'b1;                       // R10
        end else if (idle_m || pdown_m) begin
            m_ale <= quiet ? !pdown_m : 1'b1;                  // R8, R9
            m_ps  <= 1'b1;
        end else begin
            int nph;
            bit ndc, nex;
            nph = (m_ph == 12) ? 1 : m_ph + 1;
            ndc = m_dc; nex = m_ex;
            if (nph == 1) begin
                ndc = data_req;
                nex = !m_ea || (pc >= 16'd32768);              // R5
            end
            m_ph <= nph; m_dc <= ndc; m_ex <= nex;
            m_ale <= want_ale(nph, ndc, nex, quiet);
            m_ps  <= want_psen_n(nph, ndc, nex);
        end
    end

    // tag of the rule that governs the current expected strobes
    bit last_rst = 1'b1, last_lp = 1'b0, last_q = 1'b0, last_pd = 1'b0;
    always @(posedge clk) begin
        last_rst <= rst; last_lp <= idle_m || pdown_m;
        last_q <= quiet; last_pd <= pdown_m;
    end

    function automatic string strobe_tag();
        if (last_rst)          return "R10";
        if (last_lp && last_q) return "R8";
        if (last_lp)           return "R9";
        if (m_dc)              return "R3";
        if (last_q && m_ex)    return "R7";
        if (last_q)            return "R6";
        if (m_ex)              return "R2";
        return "R1";
    endfunction

    task automatic compare(input string tag, input string what, input bit got, input bit exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got=%0b expected=%0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_all();
        string t;
        t = strobe_tag();
        compare(t, "ale", ale, m_ale);
        compare(t, "psen_n", psen_n, m_ps);
        compare((ea_pin != m_ea) ? "R4" : "R5", "fetch_ext", fetch_ext, m_ex);
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset(input bit pin);
        rst = 1'b1; ea_pin = pin; idle_m = 1'b0; pdown_m = 1'b0;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic random_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            int r;
            r = $urandom_range(0, 3);
            pc = (r == 0) ? 16'd32767 : (r == 1) ? 16'd32768 : 16'($urandom);
            data_req = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 40) == 0) quiet = ~quiet;
            if (!idle_m && !pdown_m && $urandom_range(0, 150) == 0) begin
                idle_m  = $urandom_range(0, 1);
                pdown_m = !idle_m || ($urandom_range(0, 2) == 0);
            end else if ((idle_m || pdown_m) && $urandom_range(0, 15) == 0) begin
                idle_m = 1'b0; pdown_m = 1'b0;
            end
            step();
        end
        idle_m = 1'b0; pdown_m = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R10: reset levels
        do_reset(1'b1);
        compare("R10", "ale reset", ale, 1'b1);
        compare("R10", "psen_n reset", psen_n, 1'b1);
        compare("R10", "fetch_ext reset", fetch_ext, 1'b0);

        // R1: quiet clear, internal fetch, no data: pulses at 1 and 7 only
        pc = 16'd100; data_req = 1'b0; quiet = 1'b0;
        repeat (36) step();

        // R5: boundary addresses, internal then external
        pc = 16'd32767; repeat (24) step();
        pc = 16'd32768; repeat (24) step();

        // R6 / R7: quiet bit over internal, external and data cycles
        quiet = 1'b1; pc = 16'd10; repeat (24) step();
        pc = 16'hFFFF; repeat (24) step();
        pc = 16'd10; data_req = 1'b1; repeat (24) step();
        data_req = 1'b0;

        // R8 / R9: low-power parking and freeze
        idle_m = 1'b1; repeat (10) step();
        pdown_m = 1'b1; repeat (10) step();
        idle_m = 1'b0; repeat (5) step();
        quiet = 1'b0; repeat (5) step();
        pdown_m = 1'b0; repeat (30) step();

        // R4: flip the pin after a reset with it high
        ea_pin = 1'b0; pc = 16'd5; repeat (36) step();
        compare("R4", "fetch_ext after pin flip", fetch_ext, 1'b0);

        random_run(4000);

        // external-access low: every fetch external
        do_reset(1'b0);
        ea_pin = 1'b1;
        random_run(4000);

        do_reset(1'b1);
        random_run(3000);
        done = 1'b1;
    end

    initial begin
        int cnt;
        cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule